// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block is one programmable performance counter. Each cycle it receives a bundle of event indication lines, arranged in groups of eight: one group per event code, one line per sub-condition. An 8-bit event code in the control register picks one group, and an 8-bit unit mask chooses which of that group's eight lines take part. The active, unmasked lines are summed to give a per-cycle hit count.

That hit count then passes through the qualifiers before it reaches a wide count register. The qualifiers are:
- a threshold compare, which can be inverted;
- a rising-edge-only mode;
- a filter on the current privilege ring.

Software reaches the control word and the two halves of the count through a flat register port. Writes take effect at the clock edge. Reads are combinational. When the count wraps past all ones, a sticky overflow flag is set, and it raises an interrupt request if interrupts are enabled.

Register map, by `reg_addr`:

| Address | Register |
|---------|----------|
| 0 | Control word |
| 1 | Low 32 bits of the count |
| 2 | Upper `CNT_W-32` bits of the count, right-aligned |
| 3 | Reads zero |

Control word fields:

| Bits | Field |
|------|-------|
| 0 | Enable |
| 1 | Ring 0 (kernel) |
| 2 | Rings 1 to 3 (user) |
| 3 | Edge mode |
| 4 | Invert |
| 5 | Interrupt enable |
| 6 | Overflow flag: reads the flag, write 1 to clear |
| 7 | Reserved, reads zero |
| 15:8 | Event code |
| 23:16 | Unit mask |
| 31:24 | Threshold |

Top module: `qual_evt_ctr`

## Requirements
- R1: After reset, the control word, both count words and `irq` all read zero.
- R2: The event code (bits 15:8) selects line group `evt_lines[code*8 +: 8]`. Unit mask bit k (bits 23:16) admits line k of that group. A code of `NUM_EVT` or above selects no lines. The hit count is the number of admitted lines that are high.
- R3: With a threshold of zero and edge mode off, each enabled, privilege-qualified cycle adds the hit count (0 to 8) to the count. The invert bit has no effect in this case.
- R4: With a nonzero threshold and invert clear, the count grows by exactly 1 in each qualified cycle whose hit count is greater than or equal to the threshold, and by 0 otherwise.
- R5: With a nonzero threshold and invert set, the count grows by exactly 1 in each qualified cycle whose hit count is below the threshold.
- R6: In edge mode, the count grows by 1 only in a cycle where the qualified condition is true and was false in the last enabled cycle. With a zero threshold, the condition is "hit count nonzero".
- R7: The ring filter works as follows. Bit 1 alone counts only when `priv_lvl` is 0. Bit 2 alone counts only when `priv_lvl` is 1, 2 or 3. Both bits set, or both clear, counts at every level.
- R8: While enable is clear, the count holds its value and the edge history is not updated.
- R9: When an increment carries the count past all ones to zero, the overflow flag (bit 6) sets and stays set until software writes the control word with bit 6 at 1. `irq` is high exactly while the flag and interrupt enable (bit 5) are both set.
- R10: A write to either count word replaces that word and takes priority over any increment in the same cycle; the other word holds. A write to the control word does not block that cycle's increment, which still uses the old settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_lines | input | NUM_EVT*8 | Per-cycle event indications, eight per event code |
| priv_lvl | input | 2 | Current privilege ring, 0 to 3 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 count low, 2 count high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Overflow interrupt request |

## Verification
The wrap-around case would take about 2^40 events to reach from reset. The stimulus gets there by writing both count words to a value a few counts below all ones. It then drives a cycle with several hits, so the carry lands in a single step; with interrupts enabled and then disabled, this shows whether the flag and `irq` separate.

The frozen edge history is also hard to reach. The stimulus first arms edge mode with the condition held true. It then disables the counter, drops the condition, and re-enables the counter with the condition true again. Only a design whose history kept updating while disabled would count that last cycle. A reference model in the bench tracks every cycle, so thousands of random line patterns can be checked across the control settings.

// File: rtl/qec_pkg.sv
package qec_pkg;

   localparam int DATA_W    = 32;
   localparam int LINES     = 8;
   localparam int OVF_BIT   = 6;

   typedef struct packed {
      logic [7:0] thr;
      logic [7:0] umask;
      logic [7:0] code;
      logic       rsv;
      logic       ovf;
      logic       ie;
      logic       inv;
      logic       edge_m;
      logic       usr;
      logic       os;
      logic       en;
   } ctl_t;

   localparam logic [1:0] ADDR_CTL = 2'd0;
   localparam logic [1:0] ADDR_CLO = 2'd1;
   localparam logic [1:0] ADDR_CHI = 2'd2;

endpackage

// File: rtl/qec_evt_select.sv
module qec_evt_select #(
   parameter int NUM_EVT = 4,
   parameter int LINES   = 8,
   localparam int HW     = $clog2(LINES + 1)
) (
   input  logic [NUM_EVT*LINES-1:0] evt_lines,
   input  logic [7:0]               code,
   input  logic [LINES-1:0]         umask,
   output logic [HW-1:0]            hits
);

   logic [LINES-1:0] grp;
   logic [LINES-1:0] admitted;

   always_comb begin
      grp = '0;
      for (int i = 0; i < NUM_EVT; i++) begin
         if (code == 8'(i)) grp = evt_lines[i*LINES +: LINES];
      end
   end

   assign admitted = grp & umask;

   always_comb begin
      hits = '0;
      for (int k = 0; k < LINES; k++) hits = hits + HW'(admitted[k]);
   end

endmodule

// File: rtl/qec_qualify.sv
module qec_qualify #(
   parameter int HW      = 4,
   parameter bit EDGE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          os,
   input  logic          usr,
   input  logic          edge_m,
   input  logic          inv,
   input  logic [7:0]    thr,
   input  logic [1:0]    priv_lvl,
   input  logic [HW-1:0] hits,
   output logic [HW-1:0] amt
);

   logic       priv_ok;
   logic       thr_zero;
   logic [7:0] hits8;
   logic       cond;
   logic       cond_q;
   logic       prev_q;

   assign hits8    = 8'(hits);
   assign thr_zero = (thr == 8'd0);
   assign priv_ok  = (!os && !usr) || (os && priv_lvl == 2'd0) ||
                     (usr && priv_lvl != 2'd0);

   always_comb begin
      if (thr_zero)  cond = (hits != '0);
      else if (inv)  cond = (hits8 < thr);
      else           cond = (hits8 >= thr);
   end

   assign cond_q = cond & priv_ok;

   generate
      if (EDGE_EN) begin : g_edge
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  prev_q <= 1'b0;
            else if (en) prev_q <= cond_q;
         end
      end else begin : g_no_edge
         assign prev_q = 1'b0;
      end
   endgenerate

   always_comb begin
      if (!en)                    amt = '0;
      else if (edge_m && EDGE_EN) amt = HW'(cond_q && !prev_q);
      else if (thr_zero)          amt = priv_ok ? hits : '0;
      else                        amt = HW'(cond_q);
   end

   // R6: an edge-mode increment is never followed by another without a new edge
   assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && edge_m && amt != '0) |=> (!en || !edge_m || amt == '0));

   // R4: a nonzero threshold yields at most one count per cycle
   assert_thr_unit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (thr != 8'd0) |-> (amt <= HW'(1)));

   // R7: a ring outside the selected set never counts
   assert_priv_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((os && !usr && priv_lvl != 2'd0) || (usr && !os && priv_lvl == 2'd0))
      |-> (amt == '0));

endmodule

// File: rtl/qec_count.sv
module qec_count #(
   parameter int CNT_W  = 40,
   parameter int DATA_W = 32,
   parameter int HW     = 4,
   localparam int HI_W  = CNT_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HW-1:0]     amt,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   input  logic              clr_ovf,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);

   logic [CNT_W:0] sum;

   assign sum = {1'b0, count} + (CNT_W + 1)'(amt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (wr_lo) begin
         count[DATA_W-1:0] <= wdata;
      end else if (wr_hi) begin
         count[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
      end else begin
         count <= sum[CNT_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ovf <= 1'b0;
      else if (!wr_lo && !wr_hi && sum[CNT_W]) ovf <= 1'b1;
      else if (clr_ovf)                    ovf <= 1'b0;
   end

   // R10: a low-word write lands verbatim even with a pending increment
   assert_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (count[DATA_W-1:0] == $past(wdata)));

   // R9: the flag only drops on an explicit clear
   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);

   // R9: stepping off all ones always raises the flag
   assert_wrap_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((&count) && amt != '0 && !wr_lo && !wr_hi) |=> ovf);

endmodule

// File: rtl/qual_evt_ctr.sv
module qual_evt_ctr
   import qec_pkg::*;
#(
   parameter int NUM_EVT = 4,
   parameter int CNT_W   = 40,
   parameter bit EDGE_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EVT*LINES-1:0] evt_lines,
   input  logic [1:0]               priv_lvl,
   input  logic                     reg_wr,
   input  logic [1:0]               reg_addr,
   input  logic [DATA_W-1:0]        reg_wdata,
   output logic [DATA_W-1:0]        reg_rdata,
   output logic                     irq
);

   localparam int HW   = $clog2(LINES + 1);
   localparam int HI_W = CNT_W - DATA_W;

   generate
      if (NUM_EVT < 1 || NUM_EVT > 256) begin : g_bad_evt
         $error("NUM_EVT must lie in 1..256");
      end
      if (CNT_W <= DATA_W || CNT_W > 2 * DATA_W) begin : g_bad_cnt
         $error("CNT_W must lie in 33..64");
      end
   endgenerate

   ctl_t             ctl_q;
   logic             wr_ctl, wr_lo, wr_hi;
   logic             ovf;
   logic [CNT_W-1:0] count;
   logic [HW-1:0]    hits;
   logic [HW-1:0]    amt;

   assign wr_ctl = reg_wr && reg_addr == ADDR_CTL;
   assign wr_lo  = reg_wr && reg_addr == ADDR_CLO;
   assign wr_hi  = reg_wr && reg_addr == ADDR_CHI;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_ctl) begin
         ctl_q        <= ctl_t'(reg_wdata);
         ctl_q.ovf    <= 1'b0;
         ctl_q.rsv    <= 1'b0;
      end
   end

   qec_evt_select #(.NUM_EVT(NUM_EVT), .LINES(LINES)) sel_i (
      .evt_lines (evt_lines),
      .code      (ctl_q.code),
      .umask     (ctl_q.umask),
      .hits      (hits)
   );

   qec_qualify #(.HW(HW), .EDGE_EN(EDGE_EN)) qual_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctl_q.en),
      .os       (ctl_q.os),
      .usr      (ctl_q.usr),
      .edge_m   (ctl_q.edge_m),
      .inv      (ctl_q.inv),
      .thr      (ctl_q.thr),
      .priv_lvl (priv_lvl),
      .hits     (hits),
      .amt      (amt)
   );

   qec_count #(.CNT_W(CNT_W), .DATA_W(DATA_W), .HW(HW)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .amt     (amt),
      .wr_lo   (wr_lo),
      .wr_hi   (wr_hi),
      .wdata   (reg_wdata),
      .clr_ovf (wr_ctl && reg_wdata[OVF_BIT]),
      .count   (count),
      .ovf     (ovf)
   );

   always_comb begin
      unique case (reg_addr)
         ADDR_CTL: reg_rdata = DATA_W'(ctl_q) | (DATA_W'(ovf) << OVF_BIT);
         ADDR_CLO: reg_rdata = count[DATA_W-1:0];
         ADDR_CHI: reg_rdata = DATA_W'(count[CNT_W-1:DATA_W]);
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = ovf & ctl_q.ie;

   // R8: a disabled counter without a software write keeps its value
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_q.en && !wr_lo && !wr_hi) |=> $stable(count));

   // R10: a high-word write leaves the low word untouched
   assert_hi_keeps_lo_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (count[DATA_W-1:0] == $past(count[DATA_W-1:0])));

endmodule

// File: tb/qual_evt_ctr_tb_top.sv
`timescale 1ns/1ps
module qual_evt_ctr_tb_top;

   localparam int NE = 4;
   localparam int CW = 40;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [NE*8-1:0] lines;
   logic [1:0]    lvl;
   logic          wr;
   logic [1:0]    addr;
   logic [31:0]   wdata;
   logic [31:0]   rdata;
   logic          irq;

   int nchk = 0;
   int nfail = 0;

   logic [31:0]   m_ctl;
   logic [CW-1:0] m_cnt;
   logic          m_prev;
   logic          m_ovf;

   always #2.5 clk = ~clk;

   qual_evt_ctr #(.NUM_EVT(NE), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .evt_lines(lines), .priv_lvl(lvl),
      .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .irq(irq)
   );

   function automatic int popc(input logic [7:0] v);
      int n = 0;
      for (int k = 0; k < 8; k++) n += int'(v[k]);
      return n;
   endfunction

   function automatic logic [31:0] mkctl(input bit en, input bit os, input bit usr,
         input bit edg, input bit inv, input bit ie, input int code,
         input int um, input int thr);
      return {8'(thr), 8'(um), 8'(code), 2'b00, ie, inv, edg, usr, os, en};
   endfunction

   task automatic model_step();
      int code = int'(m_ctl[15:8]);
      int thr  = int'(m_ctl[31:24]);
      logic [7:0] grp = (code < NE) ? lines[code*8 +: 8] : 8'h00;
      int n = popc(grp & m_ctl[23:16]);
      bit os = m_ctl[1], usr = m_ctl[2];
      bit pok = (!os && !usr) || (os && lvl == 2'd0) || (usr && lvl != 2'd0);
      bit cond = (thr == 0) ? (n != 0) : (m_ctl[4] ? (n < thr) : (n >= thr));
      bit cq = cond && pok;
      int amt = 0;
      logic [CW:0] sum;
      if (m_ctl[0]) begin
         if (m_ctl[3])      amt = (cq && !m_prev) ? 1 : 0;
         else if (thr == 0) amt = pok ? n : 0;
         else               amt = cq ? 1 : 0;
         m_prev = cq;
      end
      sum = {1'b0, m_cnt} + (CW + 1)'(amt);
      if (wr && addr == 2'd1)      m_cnt[31:0] = wdata;
      else if (wr && addr == 2'd2) m_cnt[CW-1:32] = wdata[CW-33:0];
      else begin
         m_cnt = sum[CW-1:0];
         if (sum[CW]) m_ovf = 1'b1;
      end
      if (wr && addr == 2'd0) begin
         if (wdata[6] && !(sum[CW] && !(wr && (addr == 2'd1 || addr == 2'd2)))) m_ovf = 1'b0;
         m_ctl = wdata & 32'hFFFF_FF3F;
      end
   endtask

   task automatic apply(input logic w, input logic [1:0] a, input logic [31:0] d,
                        input logic [NE*8-1:0] ln, input logic [1:0] pl);
      @(negedge clk);
      wr = w; addr = a; wdata = d; lines = ln; lvl = pl;
      @(posedge clk);
      model_step();
      #1;
      wr = 1'b0;
   endtask

   task automatic step(input logic [NE*8-1:0] ln, input logic [1:0] pl);
      apply(1'b0, 2'd0, 32'h0, ln, pl);
   endtask

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      logic [31:0] v;
      addr = 2'd1; #0.2; v = rdata; chk({tag, " count low"}, 64'(v), 64'(m_cnt[31:0]));
      addr = 2'd2; #0.2; v = rdata; chk({tag, " count high"}, 64'(v), 64'(m_cnt[CW-1:32]));
      addr = 2'd0; #0.2; v = rdata;
      chk({tag, " control"}, 64'(v), 64'(m_ctl | (32'(m_ovf) << 6)));
      chk({tag, " irq"}, 64'(irq), 64'(m_ovf & m_ctl[5]));
   endtask

   task automatic wctl(input logic [31:0] c, input string tag);
      apply(1'b1, 2'd0, c, 32'h0, 2'd0);
      check_all(tag);
   endtask

   initial begin
      #(5.0 * 150000);
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int ums [6] = '{8'hFF, 8'h0F, 8'hA5, 8'h00, 8'h81, 8'h3C};
      rst_n = 1'b0; wr = 1'b0; addr = 2'd0; wdata = '0; lines = '0; lvl = 2'd0;
      m_ctl = '0; m_cnt = '0; m_prev = 1'b0; m_ovf = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      check_all("R1");

      // R2 / R3: code and mask sweep at zero threshold, invert toggled
      for (int code = 0; code <= NE; code++) begin
         for (int u = 0; u < 6; u++) begin
            wctl(mkctl(1, 0, 0, 0, code[0], 0, code, ums[u], 0), "R3 setup");
            for (int s = 0; s < 6; s++) begin
               step(32'($urandom), 2'($urandom));
               check_all((code == NE || ums[u] == 8'h00) ? "R2" : "R3");
            end
         end
      end

      // R4 / R5: threshold sweep with and without invert
      for (int inv = 0; inv < 2; inv++) begin
         for (int thr = 1; thr <= 9; thr++) begin
            wctl(mkctl(1, 0, 0, 0, inv, 0, 2, 8'hFF, thr), "R4 setup");
            for (int s = 0; s < 8; s++) begin
               step(32'($urandom), 2'($urandom));
               check_all(inv ? "R5" : "R4");
            end
         end
      end

      // R6: edge mode over several thresholds, sparse patterns
      for (int inv = 0; inv < 2; inv++) begin
         for (int t = 0; t < 3; t++) begin
            wctl(mkctl(1, 0, 0, 1, inv, 0, 1, 8'hFF, (t == 0) ? 0 : 2 * t - 1), "R6 setup");
            for (int s = 0; s < 20; s++) begin
               step(($urandom % 2) ? 32'($urandom) : 32'h0, 2'd0);
               check_all("R6");
            end
         end
      end

      // R7: ring filter combinations
      for (int os = 0; os < 2; os++) begin
         for (int usr = 0; usr < 2; usr++) begin
            wctl(mkctl(1, os, usr, 0, 0, 0, 3, 8'hFF, 0), "R7 setup");
            for (int s = 0; s < 8; s++) begin
               step(32'($urandom) | 32'h0100_0000, 2'(s));
               check_all("R7");
            end
         end
      end

      // R8: disabled hold and frozen edge history
      wctl(mkctl(1, 0, 0, 1, 0, 0, 0, 8'hFF, 1), "R8 setup");
      step(32'h0000_00FF, 2'd0); check_all("R8");
      step(32'h0000_00FF, 2'd0); check_all("R8");
      wctl(mkctl(0, 0, 0, 1, 0, 0, 0, 8'hFF, 1), "R8 setup");
      step(32'h0, 2'd0); check_all("R8");
      step(32'h0000_00FF, 2'd0); check_all("R8");
      step(32'h0, 2'd0); check_all("R8");
      wctl(mkctl(1, 0, 0, 1, 0, 0, 0, 8'hFF, 1), "R8 setup");
      step(32'h0000_00FF, 2'd0); check_all("R8");
      wctl(mkctl(0, 0, 0, 0, 0, 0, 0, 8'hFF, 0), "R8 setup");
      for (int s = 0; s < 10; s++) begin
         step(32'($urandom), 2'($urandom));
         check_all("R8");
      end

      // R9: wrap with interrupt enabled, clear, wrap with interrupt disabled
      for (int ie = 1; ie >= 0; ie--) begin
         apply(1'b1, 2'd2, 32'hFFFF_FFFF, 32'h0, 2'd0); check_all("R9 preload");
         apply(1'b1, 2'd1, 32'hFFFF_FFFD, 32'h0, 2'd0); check_all("R9 preload");
         wctl(mkctl(1, 0, 0, 0, 0, ie, 0, 8'hFF, 0), "R9 setup");
         step(32'h0000_000F, 2'd0); check_all("R9 wrap");
         step(32'h0000_0003, 2'd0); check_all("R9 sticky");
         step(32'h0, 2'd0); check_all("R9 sticky");
         wctl(mkctl(1, 0, 0, 0, 0, ie, 0, 8'hFF, 0) | 32'h40, "R9 clear");
         step(32'h0, 2'd0); check_all("R9 cleared");
      end

      // R10: software writes during active counting
      wctl(mkctl(1, 0, 0, 0, 0, 0, 0, 8'hFF, 0), "R10 setup");
      step(32'h0000_00FF, 2'd0); check_all("R10");
      apply(1'b1, 2'd1, 32'h1234_5678, 32'h0000_00FF, 2'd0); check_all("R10 low write");
      apply(1'b1, 2'd2, 32'h0000_00A5, 32'h0000_00FF, 2'd0); check_all("R10 high write");
      apply(1'b1, 2'd0, mkctl(1, 0, 0, 0, 0, 0, 1, 8'h0F, 0), 32'h0000_00FF, 2'd0);
      check_all("R10 control write");
      step(32'h0000_FF00, 2'd0); check_all("R10");

      // mixed random control and stimulus
      for (int s = 0; s < 600; s++) begin
         if (s % 25 == 0)
            apply(1'b1, 2'd0, $urandom & 32'h0F03_FF3F | 32'h0000_0001 |
                  ((s % 50 == 0) ? 32'h0 : 32'h0400_0000), 32'($urandom), 2'($urandom));
         else
            step(32'($urandom), 2'($urandom));
         check_all("R4 R6 R7 mixed");
      end

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule